// File: doc/BRIEF.md
# Push-Buffer Method Header Decoder

This block sits behind the fetch unit of a graphics command processor. It takes the 32-bit words of a command push buffer as a valid/ready stream and turns them into method writes. Each write carries a 3-bit subchannel id, a byte method address and a 32-bit data word. A header word announces a burst of payload words or carries its own small data value. The decoder then forwards the payload words as writes to consecutive methods or to one fixed method, and recognises the next header once the burst is used up.

Two header encodings are supported, and the `fmt_new` input selects between them. They differ in where the count field sits, in whether the method field counts bytes or 32-bit words, and in that only the newer encoding has an immediate-data form. The block holds no buffer. A payload word or an immediate header passes straight to the output in the cycle it is offered, and the output's ready signal gates acceptance of that word. A plain burst header is accepted at once and produces no write itself. A header the decoder cannot recognise sets a sticky error flag and is dropped.

Top module: `pbuf_method_decoder`

## Requirements
- R1: Older encoding (`fmt_new`=0), incrementing burst: the header has bits 31:29 = 000 and bits 17:16 = 00. The count is in bits 28:18, the subchannel in bits 15:13 and the byte method in bits 12:0. The next `count` words become writes, and the k-th write (from 0) goes to method + 4k, modulo 2^15.
- R2: Older encoding, bits 31:29 = 010 (bit 30 set) and bits 17:16 = 00: a burst with the same fields as R1, but every payload write goes to the header's method.
- R3: Newer encoding (`fmt_new`=1), bits 31:29 = 001: an incrementing burst with the count in bits 28:16, the subchannel in bits 15:13 and a word method in bits 12:0. The byte method is the word method times 4, and it advances by 4 per write, modulo 2^15.
- R4: Newer encoding, bits 31:29 = 011: a burst with the R3 fields, where every payload write goes to the same byte method.
- R5: Newer encoding, bits 31:29 = 100: immediate header. It produces exactly one write carrying the subchannel and byte method decoded as in R3, with data equal to bits 28:16 zero-extended. The word that follows it is decoded as a header.
- R6: A burst header with a count of zero produces no write, and the next word is decoded as a header.
- R7: Any other header pattern is unrecognised: a newer-encoding top field outside 001/011/100, or an older-encoding header with bit 31 or bit 29 set or with bits 17:16 nonzero. The word is consumed with no write, the next word is a header, and `err_flag` goes high and stays high until reset.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low. No word is consumed and no write is lost or duplicated.
- R9: After reset, `out_valid` and `err_flag` are low and the first word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_new | input | 1 | 0 selects the older header encoding, 1 the newer one; held stable within a burst |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input push-buffer word |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| out_valid | output | 1 | Method write valid |
| out_ready | input | 1 | Downstream accepts the write |
| out_subch | output | 3 | Subchannel id of the write |
| out_mthd | output | 15 | Byte method address of the write |
| out_data | output | 32 | Data word of the write |
| err_flag | output | 1 | Sticky unrecognised-header flag |

## Verification
A write appears in the same cycle as the word that causes it, whether a payload word or an immediate header, because the decoder's output path is combinational. The bench therefore drives inputs just after the falling edge and samples outputs a quarter period later, before the rising edge that commits the handshake. Burst state and the error flag change on that rising edge, so their effect on the next word and on `err_flag` is checked in the following sample window. During every stalled cycle the bench also checks that `in_ready` is low.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SUBCH_W   = 3;
  localparam int unsigned CNT_W     = 13;
  localparam int unsigned OLD_CNT_W = 11;
  localparam int unsigned MFLD_W    = 13;
  localparam int unsigned MTHD_W    = MFLD_W + 2;
  localparam int unsigned IMM_W     = 13;

  typedef enum logic [1:0] {
    HK_BURST = 2'd0,
    HK_IMM   = 2'd1,
    HK_BAD   = 2'd2
  } hdr_kind_e;

  typedef struct packed {
    hdr_kind_e            kind;
    logic                 incr;
    logic [SUBCH_W-1:0]   subch;
    logic [CNT_W-1:0]     cnt;
    logic [MTHD_W-1:0]    mthd;
    logic [WORD_W-1:0]    imm;
  } hdr_info_t;
endpackage

// File: rtl/pbd_hdr_decode.sv
module pbd_hdr_decode
  import pbd_pkg::*;
(
  input  logic              fmt_new,
  input  logic [WORD_W-1:0] word,
  output hdr_info_t         info
);
  always_comb begin
    info       = '0;
    info.kind  = HK_BAD;
    info.subch = word[15:13];
    if (!fmt_new) begin
      info.cnt  = {{(CNT_W-OLD_CNT_W){1'b0}}, word[28:18]};
      info.mthd = {2'b00, word[12:0]};
      if (!word[31] && !word[29] && (word[17:16] == 2'b00)) begin
        info.kind = HK_BURST;
        info.incr = !word[30];
      end
    end else begin
      info.cnt  = word[28:16];
      info.mthd = {word[12:0], 2'b00};
      info.imm  = {{(WORD_W-IMM_W){1'b0}}, word[28:16]};
      case (word[31:29])
        3'b001: begin info.kind = HK_BURST; info.incr = 1'b1; end
        3'b011: begin info.kind = HK_BURST; info.incr = 1'b0; end
        3'b100: info.kind = HK_IMM;
        default: info.kind = HK_BAD;
      endcase
    end
  end
endmodule

// File: rtl/pbd_burst_track.sv
module pbd_burst_track
  import pbd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  hdr_info_t          hdr,
  input  logic               step,
  output logic               busy,
  output logic [SUBCH_W-1:0] subch,
  output logic [MTHD_W-1:0]  mthd
);
  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [MTHD_W-1:0]  mthd_q, mthd_d;
  logic [SUBCH_W-1:0] subch_q, subch_d;
  logic               incr_q, incr_d;
  logic               en;

  always_comb begin
    busy_d  = busy_q;
    left_d  = left_q;
    mthd_d  = mthd_q;
    subch_d = subch_q;
    incr_d  = incr_q;
    en      = load | step;
    if (load) begin
      busy_d  = 1'b1;
      left_d  = hdr.cnt;
      mthd_d  = hdr.mthd;
      subch_d = hdr.subch;
      incr_d  = hdr.incr;
    end else if (step) begin
      left_d = left_q - 1'b1;
      busy_d = (left_q != {{(CNT_W-1){1'b0}}, 1'b1});
      if (incr_q) mthd_d = mthd_q + MTHD_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      left_q  <= '0;
      mthd_q  <= '0;
      subch_q <= '0;
      incr_q  <= 1'b0;
    end else if (en) begin
      busy_q  <= busy_d;
      left_q  <= left_d;
      mthd_q  <= mthd_d;
      subch_q <= subch_d;
      incr_q  <= incr_d;
    end
  end

  assign busy  = busy_q;
  assign subch = subch_q;
  assign mthd  = mthd_q;

  assert_mthd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && incr_q && step) |=> (mthd_q == $past(mthd_q) + MTHD_W'(4)));
  assert_mthd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !incr_q) |=> $stable(mthd_q));
  assert_zero_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && hdr.cnt == '0) |=> !busy_q);
endmodule

// File: rtl/pbuf_method_decoder.sv
module pbuf_method_decoder
  import pbd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fmt_new,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SUBCH_W-1:0] out_subch,
  output logic [MTHD_W-1:0]  out_mthd,
  output logic [WORD_W-1:0]  out_data,
  output logic               err_flag
);
  hdr_info_t          hdr;
  logic               busy, load, step, set_err;
  logic [SUBCH_W-1:0] trk_subch;
  logic [MTHD_W-1:0]  trk_mthd;
  logic               err_q, err_d;

  pbd_hdr_decode u_dec (
    .fmt_new (fmt_new),
    .word    (in_data),
    .info    (hdr)
  );

  pbd_burst_track u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .hdr   (hdr),
    .step  (step),
    .busy  (busy),
    .subch (trk_subch),
    .mthd  (trk_mthd)
  );

  always_comb begin
    out_valid = 1'b0;
    out_subch = trk_subch;
    out_mthd  = trk_mthd;
    out_data  = in_data;
    in_ready  = 1'b0;
    load      = 1'b0;
    step      = 1'b0;
    set_err   = 1'b0;
    if (busy) begin
      out_valid = in_valid;
      in_ready  = out_ready;
      step      = in_valid && out_ready;
    end else begin
      case (hdr.kind)
        HK_IMM: begin
          out_valid = in_valid;
          out_subch = hdr.subch;
          out_mthd  = hdr.mthd;
          out_data  = hdr.imm;
          in_ready  = out_ready;
        end
        HK_BURST: begin
          in_ready = 1'b1;
          load     = in_valid && (hdr.cnt != '0);
        end
        default: begin
          in_ready = 1'b1;
          set_err  = in_valid;
        end
      endcase
    end
  end

  always_comb err_d = err_q | set_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (set_err) err_q <= err_d;
  end

  assign err_flag = err_q;

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_bad_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |-> !out_valid);
  assert_imm_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hdr.kind == HK_IMM && in_valid && out_ready) |=> !busy);
endmodule

// File: tb/test_pbuf_method_decoder.sv
module test_pbuf_method_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fmt_new, in_valid, out_ready;
  logic [31:0] in_data;
  logic        in_ready, out_valid, err_flag;
  logic [2:0]  out_subch;
  logic [14:0] out_mthd;
  logic [31:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [31:0] words[$];
  logic [2:0]  e_sub[$];
  logic [14:0] e_mthd[$];
  logic [31:0] e_data[$];
  string       e_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pbuf_method_decoder i_pbuf_method_decoder (
    .clk(clk), .rst_n(rst_n), .fmt_new(fmt_new), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_subch(out_subch), .out_mthd(out_mthd),
    .out_data(out_data), .err_flag(err_flag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_old(bit fixed, int cnt, int sc, int m);
    return (fixed ? 32'h4000_0000 : 32'h0) | ((cnt & 32'h7FF) << 18) | ((sc & 7) << 13) | (m & 32'h1FFF);
  endfunction

  function automatic logic [31:0] mk_new(int top, int cnt, int sc, int mw);
    return ((top & 7) << 29) | ((cnt & 32'h1FFF) << 16) | ((sc & 7) << 13) | (mw & 32'h1FFF);
  endfunction

  task automatic push_burst(bit newf, bit fixed, int cnt, int sc, int m);
    string tag;
    logic [14:0] base;
    if (newf) begin
      words.push_back(mk_new(fixed ? 3 : 1, cnt, sc, m));
      base = 15'(m * 4);
      tag  = cnt == 0 ? "R6" : (fixed ? "R4" : "R3");
    end else begin
      words.push_back(mk_old(fixed, cnt, sc, m));
      base = 15'(m);
      tag  = cnt == 0 ? "R6" : (fixed ? "R2" : "R1");
    end
    for (int k = 0; k < cnt; k++) begin
      logic [31:0] d = $urandom;
      words.push_back(d);
      e_sub.push_back(3'(sc));
      e_mthd.push_back(fixed ? base : 15'(base + 15'(4 * k)));
      e_data.push_back(d);
      e_tag.push_back(tag);
    end
  endtask

  task automatic push_imm(int d, int sc, int mw);
    words.push_back(mk_new(4, d, sc, mw));
    e_sub.push_back(3'(sc));
    e_mthd.push_back(15'(mw * 4));
    e_data.push_back(32'(d & 32'h1FFF));
    e_tag.push_back("R5");
  endtask

  task automatic run(bit newf, int ready_pct, int valid_pct);
    int idx = 0;
    fmt_new = newf;
    while ((idx < words.size() || e_sub.size() != 0) && cyc < MAX_CYC) begin
      @(negedge clk);
      cyc++;
      in_valid  = (idx < words.size()) && (($urandom % 100) < valid_pct);
      in_data   = (idx < words.size()) ? words[idx] : 32'h0;
      out_ready = ($urandom % 100) < ready_pct;
      #(CLK_PERIOD/4);
      if (out_valid && !out_ready) check("R8 stall", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (e_sub.size() == 0) check("R8 extra write", 64'd1, 64'd0);
        else begin
          string t = e_tag.pop_front();
          check({t, " subch"}, 64'(out_subch), 64'(e_sub.pop_front()));
          check({t, " mthd"},  64'(out_mthd),  64'(e_mthd.pop_front()));
          check({t, " data"},  64'(out_data),  64'(e_data.pop_front()));
        end
      end
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (cyc >= MAX_CYC) check("watchdog", 64'd1, 64'd0);
    check("R8 all writes delivered", 64'(e_sub.size()), 64'd0);
    words.delete();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; fmt_new = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check("R9 out_valid reset", 64'(out_valid), 64'd0);
    check("R9 err reset", 64'(err_flag), 64'd0);
    rst_n = 1'b1;

    // R9 first word is a header; R1/R2/R6 directed, older encoding
    push_burst(0, 0, 3, 5, 32'h100);
    push_burst(0, 0, 0, 1, 32'h40);
    push_burst(0, 1, 4, 2, 32'h1FFC);
    push_burst(0, 0, 2, 7, 32'h1FFC);
    run(0, 100, 100);
    check("R7 err stays low", 64'(err_flag), 64'd0);

    // R3/R4/R5/R6 directed, newer encoding, incl. 15-bit wrap
    push_burst(1, 0, 3, 3, 32'h1FFF);
    push_imm(32'h1FFF, 6, 32'h0A);
    push_burst(1, 0, 0, 0, 32'h10);
    push_imm(0, 1, 32'h1FFF);
    push_burst(1, 1, 2, 4, 32'h0123);
    run(1, 60, 80);
    check("R7 err stays low newer", 64'(err_flag), 64'd0);

    // R7: unrecognised headers dropped, flag sticky
    words.push_back(32'hE000_1234);
    push_burst(1, 0, 2, 2, 32'h20);
    run(1, 100, 100);
    check("R7 err set", 64'(err_flag), 64'd1);
    words.push_back(32'h0001_0000);
    words.push_back(32'h2000_0000);
    push_burst(0, 1, 2, 3, 32'h80);
    run(0, 70, 70);
    check("R7 err sticky", 64'(err_flag), 64'd1);

    // random mix
    for (int ph = 0; ph < 6; ph++) begin
      bit nf = ph[0];
      for (int h = 0; h < 40; h++) begin
        int r = $urandom % 10;
        if (nf && r < 2) push_imm($urandom, $urandom, $urandom);
        else push_burst(nf, r[0], $urandom % 6, $urandom, nf ? $urandom : ($urandom & 32'h1FFC));
      end
      run(nf, 30 + 10 * ph, 50 + 8 * ph);
    end
    check("R7 err sticky end", 64'(err_flag), 64'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule